// File: doc/BRIEF.md
# Modulo-Six Up/Down Counter with Seven-Segment Output

This block counts through six values, 0 to 5, and shows the current value on one seven-segment digit. One direction input picks the way the count moves. When it is high the count rises and goes from 5 back to 0. When it is low the count falls and goes from 0 back to 5. The count is held in a small state register whose contents are also driven out as a binary value.

The seven segment controls are a Moore function of the state alone. They are active-low, so a segment lights when its control is 0. A parent block drives the clock and the direction bit, and wires the segment outputs straight to a digit. An active-low asynchronous reset puts the count at zero.

Top module: `mod6_updown_disp`

## Requirements
- R1: While rst_ni is low, q_o is 0 at once, without waiting for a clock edge, and the segments show digit 0.
- R2: q_o changes only on a rising edge of clk_i. A change of up_i between edges leaves q_o unchanged.
- R3: With up_i = 1 at a rising edge, q_o becomes the previous value plus one, for previous values 0 to 4.
- R4: With up_i = 1 at a rising edge and q_o = 5, q_o becomes 0.
- R5: With up_i = 0 at a rising edge, q_o becomes the previous value minus one, for previous values 1 to 5.
- R6: With up_i = 0 at a rising edge and q_o = 0, q_o becomes 5.
- R7: q_o carries the count as a plain binary number and never shows a value above 5.
- R8: The segment outputs, read as the bit string {seg_a_o..seg_g_o} with 0 meaning lit, are: 0 = 0000001, 1 = 1001111, 2 = 0010010, 3 = 0000110, 4 = 1001100, 5 = 0100100.
- R9: The segment outputs depend only on q_o. Changing up_i does not change them.
- R10: up_i is sampled at each rising edge, so a new direction applies at the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the state updates on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the count to 0 |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| q_o | output | 3 | Current count in binary |
| seg_a_o | output | 1 | Segment a control, active low |
| seg_b_o | output | 1 | Segment b control, active low |
| seg_c_o | output | 1 | Segment c control, active low |
| seg_d_o | output | 1 | Segment d control, active low |
| seg_e_o | output | 1 | Segment e control, active low |
| seg_f_o | output | 1 | Segment f control, active low |
| seg_g_o | output | 1 | Segment g control, active low |

## Verification
A new count appears on q_o one register stage after the rising edge that samples up_i. The segment outputs follow in the same cycle, because they are decoded from the state with no register in between. The bench therefore drives up_i at the falling edge, lets one rising edge pass, and reads q_o and the segments at the next falling edge. The reset result is due with no clock edge at all, so it is read a few time units after rst_ni falls in the middle of a cycle. The checks that up_i has no effect read both outputs after several toggles of up_i that happen between edges.

// File: rtl/mod6_pkg.sv
package mod6_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;  // {a,b,c,d,e,f,g}, 0 = lit

  localparam seg_t SEG_BLANK = 7'b1111111;

  function automatic seg_t seg_of(input int unsigned digit);
    seg_t s;
    case (digit)
      0: s = 7'b0000001;
      1: s = 7'b1001111;
      2: s = 7'b0010010;
      3: s = 7'b0000110;
      4: s = 7'b1001100;
      5: s = 7'b0100100;
      6: s = 7'b0100000;
      7: s = 7'b0001111;
      8: s = 7'b0000000;
      9: s = 7'b0000100;
      default: s = SEG_BLANK;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/mod6_state_reg.sv
module mod6_state_reg #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/mod6_next.sv
module mod6_next #(
  parameter int MODULUS = 6,
  parameter int W       = 3
) (
  input  logic [W-1:0] q_i,
  input  logic         up_i,
  output logic [W-1:0] ns_o
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  always_comb begin
    if (int'(q_i) >= MODULUS) ns_o = '0;  // recover from unused codes
    else if (up_i)            ns_o = (q_i == TOP) ? '0 : q_i + W'(1);
    else                      ns_o = (q_i == '0) ? TOP : q_i - W'(1);
  end
endmodule

// File: rtl/mod6_seg_dec.sv
module mod6_seg_dec
  import mod6_pkg::*;
#(
  parameter int MODULUS = 6,
  parameter int W       = 3
) (
  input  logic [W-1:0] q_i,
  output seg_t         seg_o
);
  always_comb begin
    if (int'(q_i) >= MODULUS) seg_o = SEG_BLANK;
    else                      seg_o = seg_of(int'(q_i));
  end
endmodule

// File: rtl/mod6_updown_disp.sv
module mod6_updown_disp
  import mod6_pkg::*;
#(
  parameter  int MODULUS = 6,
  localparam int W       = $clog2(MODULUS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  output logic [W-1:0] q_o,
  output logic         seg_a_o,
  output logic         seg_b_o,
  output logic         seg_c_o,
  output logic         seg_d_o,
  output logic         seg_e_o,
  output logic         seg_f_o,
  output logic         seg_g_o
);
  logic [W-1:0] ns;
  seg_t         seg;

  mod6_state_reg #(.W(W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ns),
    .q_o   (q_o)
  );

  mod6_next #(.MODULUS(MODULUS), .W(W)) u_next (
    .q_i (q_o),
    .up_i(up_i),
    .ns_o(ns)
  );

  mod6_seg_dec #(.MODULUS(MODULUS), .W(W)) u_dec (
    .q_i  (q_o),
    .seg_o(seg)
  );

  assign {seg_a_o, seg_b_o, seg_c_o, seg_d_o, seg_e_o, seg_f_o, seg_g_o} = seg;
endmodule

// File: rtl/mod6_updown_disp_chk.sv
module mod6_updown_disp_chk #(
  parameter int MODULUS = 6,
  parameter int W       = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         up_i,
  input logic [W-1:0] q_o,
  input logic         seg_a_o,
  input logic         seg_b_o,
  input logic         seg_c_o,
  input logic         seg_d_o,
  input logic         seg_e_o,
  input logic         seg_f_o,
  input logic         seg_g_o
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);
  logic [6:0] seg;
  assign seg = {seg_a_o, seg_b_o, seg_c_o, seg_d_o, seg_e_o, seg_f_o, seg_g_o};

  // R1
  always @(negedge rst_ni) #1 reset_clear_chk: assert (q_o == '0);

  // R7
  in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(q_o) < MODULUS);

  // R3
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && q_o != TOP) |=> q_o == $past(q_o) + W'(1));

  // R4
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && q_o == TOP) |=> q_o == '0);

  // R5
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && q_o != '0) |=> q_o == $past(q_o) - W'(1));

  // R6
  down_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && q_o == '0) |=> q_o == TOP);

  // R9
  moore_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(q_o) |-> $stable(seg));

  // R8
  digit_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seg) < 7);
endmodule

bind mod6_updown_disp mod6_updown_disp_chk #(.MODULUS(MODULUS), .W(W)) u_chk (.*);

// File: tb/mod6_updown_disp_test.sv
`timescale 1ns/1ps
module mod6_updown_disp_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       up_i = 1'b1;
  logic [2:0] q_o;
  logic       seg_a_o, seg_b_o, seg_c_o, seg_d_o, seg_e_o, seg_f_o, seg_g_o;

  int checks = 0;
  int errors = 0;
  int exp_q  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mod6_updown_disp uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .up_i   (up_i),
    .q_o    (q_o),
    .seg_a_o(seg_a_o),
    .seg_b_o(seg_b_o),
    .seg_c_o(seg_c_o),
    .seg_d_o(seg_d_o),
    .seg_e_o(seg_e_o),
    .seg_f_o(seg_f_o),
    .seg_g_o(seg_g_o)
  );

  function automatic logic [6:0] want_seg(input int d);
    case (d)
      0: return 7'b0000001;
      1: return 7'b1001111;
      2: return 7'b0010010;
      3: return 7'b0000110;
      4: return 7'b1001100;
      5: return 7'b0100100;
      default: return 7'b1111111;
    endcase
  endfunction

  function automatic logic [6:0] seg_now();
    return {seg_a_o, seg_b_o, seg_c_o, seg_d_o, seg_e_o, seg_f_o, seg_g_o};
  endfunction

  task automatic check_q(input int exp, input string req);
    checks++;
    if (int'(q_o) !== exp) begin
      errors++;
      $display("FAIL %s: q_o actual %0d expected %0d", req, q_o, exp);
    end
  endtask

  task automatic check_seg(input int digit, input string req);
    checks++;
    if (seg_now() !== want_seg(digit)) begin
      errors++;
      $display("FAIL %s: seg actual %b expected %b", req, seg_now(), want_seg(digit));
    end
  endtask

  task automatic check_range();
    checks++;
    if (q_o > 3'd5) begin
      errors++;
      $display("FAIL R7: q_o actual %0d expected <= 5", q_o);
    end
  endtask

  // drive at falling edge, one rising edge, read at next falling edge
  task automatic step(input bit dir, input string req);
    up_i = dir;
    @(posedge clk_i);
    @(negedge clk_i);
    if (dir) exp_q = (exp_q == 5) ? 0 : exp_q + 1;
    else     exp_q = (exp_q == 0) ? 5 : exp_q - 1;
    check_q(exp_q, req);
    check_seg(exp_q, "R8");
    check_range();
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #(CLK_PERIOD/4);
    check_q(0, "R1");
    check_seg(0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_q = 0;
  endtask

  task automatic t_count_up();
    for (int i = 0; i < 8; i++)
      step(1'b1, (exp_q == 5) ? "R4" : "R3");
  endtask

  task automatic t_count_down();
    for (int i = 0; i < 8; i++)
      step(1'b0, (exp_q == 0) ? "R6" : "R5");
  endtask

  task automatic t_dir_flip();
    step(1'b1, "R10");
    step(1'b0, "R10");
    step(1'b0, "R10");
    step(1'b1, "R10");
    step(1'b1, "R10");
    step(1'b0, "R10");
  endtask

  // toggle up_i between edges: no state or segment change
  task automatic t_dir_between_edges();
    for (int i = 0; i < 4; i++) begin
      #1 up_i = ~up_i;
    end
    check_q(exp_q, "R2");
    check_seg(exp_q, "R9");
  endtask

  task automatic t_async_reset();
    step(1'b1, "R3");
    step(1'b1, "R3");
    #1 rst_ni = 1'b0;
    #1;
    check_q(0, "R1");
    check_seg(0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_q = 0;
    step(1'b0, "R6");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_count_up();
    t_dir_between_edges();
    t_count_down();
    t_dir_between_edges();
    t_dir_flip();
    t_async_reset();
    t_dir_between_edges();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule